// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block reads and writes 16-bit registers inside a PHY that are not directly addressable. Such registers are reached through two words: a 20-bit control word that the sequencer drives toward the PHY, and a 17-bit status word that the PHY returns. A requester presents one operation: a read or a write, a 16-bit register address and, for writes, 16 bits of data. The sequencer then walks the control word through a fixed series of steps. Each step is a four-phase handshake: raise a strobe, wait for the acknowledge to go high, drop the strobe, wait for the acknowledge to go low.

Every operation starts with an address step. A read then adds one read step, and the sequencer captures the returned data while the acknowledge is high. A write adds a data-capture step and then a separate commit step. Each acknowledge wait samples the status word a bounded number of times, with a fixed gap between samples. If the expected level never appears, the sequencer abandons the operation. It then parks the control word at zero and reports completion with an error flag. New requests are taken only while the sequencer is idle.

Top module: `phy_reg_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the control word is zero, and busy, done, timeoutErr and rdData are all zero.
- R2: Control word encoding: bits 15:0 carry the address or data field; bit 16 is the address-capture strobe, bit 17 the data-capture strobe, bit 18 the write-commit strobe and bit 19 the read strobe. At most one strobe is high in any cycle.
- R3: Status word encoding: bit 16 is the acknowledge and bits 15:0 carry read data. rdData changes only on a clock edge where the sampled acknowledge is high.
- R4: Every operation begins with an address step. The address is first driven with no strobe for one cycle. Then bit 16 is added until the acknowledge is seen high. Then the address is driven alone until the acknowledge is seen low.
- R5: A read drives only bit 19 until the acknowledge is seen high, and captures status bits 15:0 at that sample into rdData. It then drives an all-zero word until the acknowledge is seen low, and reports done.
- R6: A write first drives the data with no strobe for one cycle. It then adds bit 17 until the acknowledge is high, and drives the data alone until the acknowledge is low. It then drives only bit 18 until the acknowledge is high, and the data alone until the acknowledge is low. Finally it drives zero for one cycle and reports done.
- R7: The strobe sequence seen by the PHY at acknowledge rises is address-capture then read for a read, and address-capture, data-capture, write-commit for a write. The address field equals the requested address and the data field equals the requested data.
- R8: In an acknowledge wait, the first sample is taken at the first clock edge in that step, and later samples follow every POLL_GAP+1 cycles. With the default POLL_GAP of 2, a read whose acknowledge follows each change after exactly one cycle completes with done visible 17 cycles after the accepting edge. An acknowledge level that is present at the tenth sample (MAX_POLLS) is accepted.
- R9: If MAX_POLLS samples in one wait all miss, the operation is aborted. The control word is zero in the cycle before done and in the done cycle, timeoutErr is high, and rdData keeps its previous value. A timeout on the first wait shows done 3 + (MAX_POLLS-1)*(POLL_GAP+1) cycles after the accepting edge.
- R10: done is a single-cycle pulse per accepted operation, and timeoutErr is high only together with done, only on an aborted operation.
- R11: A request is accepted on any edge where busy is low, including the cycle in which done is shown, and busy is high after that edge. Requests presented while busy have no effect on the PHY and produce no extra done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; taken when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | PHY register address |
| reqData | input | 16 | Write data |
| busy | output | 1 | Operation in progress |
| ctrlWord | output | 20 | Control word to the PHY |
| statWord | input | 17 | Status word from the PHY |
| rdData | output | 16 | Data captured by the last successful read |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | Set with done when the operation was aborted |

## Verification
Two events can coincide in one clock edge. The first is the arrival of the acknowledge and the last allowed sample of a wait, where success must win over abort. The second is completion and a new request, which arrive together when done is shown. The first is provoked by sweeping the responder's acknowledge latency up to exactly (MAX_POLLS-1)*(POLL_GAP+1) cycles and one beyond, and is judged by done with or without timeoutErr and by the PHY contents read back afterwards. The second is provoked by issuing every operation in the very cycle the previous one shows done, and is judged by busy rising and by the correct result of that next operation.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int FIELD_W      = 16;
  localparam int CAP_ADDR_POS = 16;
  localparam int CAP_DATA_POS = 17;
  localparam int COMMIT_POS   = 18;
  localparam int READ_POS     = 19;
  localparam int CTRL_W       = 20;
  localparam int ACK_POS      = 16;
  localparam int STAT_W       = 17;

  typedef enum logic [1:0] {
    FLD_ZERO = 2'd0,
    FLD_ADDR = 2'd1,
    FLD_DATA = 2'd2
  } fld_sel_e;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    fld_sel_e fldSel;
    logic     capAddr;
    logic     capData;
    logic     wrStb;
    logic     rdStb;
    logic     loadReq;
    logic     grabRead;
    logic     pollClear;
    logic     pollAdvance;
    logic     finishOk;
    logic     finishErr;
  } seq_ctl_s;

endpackage

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int POLL_GAP  = 2,
  parameter int MAX_POLLS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_ctl_s            ctl,
  input  logic [FIELD_W-1:0]  reqAddr,
  input  logic [FIELD_W-1:0]  reqData,
  input  logic [STAT_W-1:0]   statWord,
  output logic [CTRL_W-1:0]   ctrlWord,
  output logic [FIELD_W-1:0]  rdData,
  output logic                done,
  output logic                timeoutErr,
  output logic                ackIn,
  output logic                pollDue,
  output logic                pollLast
);

  localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam int GAP_W  = (POLL_GAP > 0) ? $clog2(POLL_GAP + 1) : 1;

  logic [FIELD_W-1:0] addrQ;
  logic [FIELD_W-1:0] dataQ;
  logic [FIELD_W-1:0] rdDataQ;
  logic [FIELD_W-1:0] fieldVal;
  logic [POLL_W-1:0]  pollCnt;
  logic               doneQ;
  logic               errQ;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (ctl.loadReq) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  // control word assembly
  always_comb begin
    case (ctl.fldSel)
      FLD_ADDR: fieldVal = addrQ;
      FLD_DATA: fieldVal = dataQ;
      default:  fieldVal = '0;
    endcase
  end

  always_comb begin
    ctrlWord                  = '0;
    ctrlWord[FIELD_W-1:0]     = fieldVal;
    ctrlWord[CAP_ADDR_POS]    = ctl.capAddr;
    ctrlWord[CAP_DATA_POS]    = ctl.capData;
    ctrlWord[COMMIT_POS]      = ctl.wrStb;
    ctrlWord[READ_POS]        = ctl.rdStb;
  end

  assign ackIn = statWord[ACK_POS];

  // read data capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (ctl.grabRead) begin
      rdDataQ <= statWord[FIELD_W-1:0];
    end
  end

  // sample counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (ctl.pollClear) begin
      pollCnt <= '0;
    end else if (ctl.pollAdvance) begin
      pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  assign pollLast = (pollCnt == POLL_W'(MAX_POLLS - 1));

  // gap timer between samples
  generate
    if (POLL_GAP == 0) begin : g_noGap
      assign pollDue = 1'b1;
    end else begin : g_gap
      logic [GAP_W-1:0] gapCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          gapCnt <= '0;
        end else if (ctl.pollClear) begin
          gapCnt <= '0;
        end else if (ctl.pollAdvance) begin
          gapCnt <= GAP_W'(POLL_GAP);
        end else if (gapCnt != '0) begin
          gapCnt <= gapCnt - GAP_W'(1);
        end
      end
      assign pollDue = (gapCnt == '0);
    end
  endgenerate

  // completion flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= ctl.finishOk | ctl.finishErr;
      errQ  <= ctl.finishErr;
    end
  end

  assign rdData     = rdDataQ;
  assign done       = doneQ;
  assign timeoutErr = errQ;

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic     ackIn,
  input  logic     pollDue,
  input  logic     pollLast,
  output seq_ctl_s ctl,
  output logic     busy
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR_PUT,
    S_ADDR_CAP,
    S_ADDR_REL,
    S_RD_STB,
    S_RD_REL,
    S_WD_PUT,
    S_WD_CAP,
    S_WD_REL,
    S_WR_STB,
    S_WR_REL,
    S_WR_END,
    S_ABORT
  } seq_state_e;

  seq_state_e state;
  seq_state_e nxt;
  seq_state_e passState;
  logic       writeQ;
  logic       waiting;
  logic       expAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      writeQ <= 1'b0;
    end else begin
      state <= nxt;
      if (ctl.loadReq) writeQ <= reqWrite;
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.pollClear = 1'b1;
    nxt           = state;
    passState     = state;
    waiting       = 1'b0;
    expAck        = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          nxt         = S_ADDR_PUT;
        end
      end
      S_ADDR_PUT: begin
        ctl.fldSel = FLD_ADDR;
        nxt        = S_ADDR_CAP;
      end
      S_ADDR_CAP: begin
        ctl.fldSel  = FLD_ADDR;
        ctl.capAddr = 1'b1;
        waiting     = 1'b1;
        expAck      = 1'b1;
        passState   = S_ADDR_REL;
      end
      S_ADDR_REL: begin
        ctl.fldSel = FLD_ADDR;
        waiting    = 1'b1;
        passState  = writeQ ? S_WD_PUT : S_RD_STB;
      end
      S_RD_STB: begin
        ctl.rdStb = 1'b1;
        waiting   = 1'b1;
        expAck    = 1'b1;
        passState = S_RD_REL;
      end
      S_RD_REL: begin
        waiting   = 1'b1;
        passState = S_IDLE;
      end
      S_WD_PUT: begin
        ctl.fldSel = FLD_DATA;
        nxt        = S_WD_CAP;
      end
      S_WD_CAP: begin
        ctl.fldSel  = FLD_DATA;
        ctl.capData = 1'b1;
        waiting     = 1'b1;
        expAck      = 1'b1;
        passState   = S_WD_REL;
      end
      S_WD_REL: begin
        ctl.fldSel = FLD_DATA;
        waiting    = 1'b1;
        passState  = S_WR_STB;
      end
      S_WR_STB: begin
        ctl.wrStb = 1'b1;
        waiting   = 1'b1;
        expAck    = 1'b1;
        passState = S_WR_REL;
      end
      S_WR_REL: begin
        ctl.fldSel = FLD_DATA;
        waiting    = 1'b1;
        passState  = S_WR_END;
      end
      S_WR_END: begin
        ctl.finishOk = 1'b1;
        nxt          = S_IDLE;
      end
      S_ABORT: begin
        ctl.finishErr = 1'b1;
        nxt           = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase

    if (waiting) begin
      ctl.pollClear = 1'b0;
      if (pollDue) begin
        if (ackIn == expAck) begin
          nxt           = passState;
          ctl.pollClear = 1'b1;
          ctl.grabRead  = (state == S_RD_STB);
          ctl.finishOk  = (state == S_RD_REL);
        end else if (pollLast) begin
          nxt           = S_ABORT;
          ctl.pollClear = 1'b1;
        end else begin
          ctl.pollAdvance = 1'b1;
        end
      end
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq
  import phy_seq_pkg::*;
#(
  parameter int POLL_GAP  = 2,
  parameter int MAX_POLLS = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [15:0] reqData,
  output logic        busy,
  output logic [19:0] ctrlWord,
  input  logic [16:0] statWord,
  output logic [15:0] rdData,
  output logic        done,
  output logic        timeoutErr
);

  seq_ctl_s ctl;
  logic     ackIn;
  logic     pollDue;
  logic     pollLast;

  phy_seq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .ackIn    (ackIn),
    .pollDue  (pollDue),
    .pollLast (pollLast),
    .ctl      (ctl),
    .busy     (busy)
  );

  phy_seq_dp #(
    .POLL_GAP  (POLL_GAP),
    .MAX_POLLS (MAX_POLLS)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .statWord   (statWord),
    .ctrlWord   (ctrlWord),
    .rdData     (rdData),
    .done       (done),
    .timeoutErr (timeoutErr),
    .ackIn      (ackIn),
    .pollDue    (pollDue),
    .pollLast   (pollLast)
  );

endmodule

// File: rtl/phy_reg_seq_chk.sv
module phy_reg_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        busy,
  input logic [19:0] ctrlWord,
  input logic [16:0] statWord,
  input logic [15:0] rdData,
  input logic        done,
  input logic        timeoutErr
);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlWord[19:16]));

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  zero_before_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ctrlWord == 20'h0) && ($past(ctrlWord) == 20'h0));

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R5
  rddata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> $stable(rdData));

  // R3
  rddata_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $past(statWord[16]));

endmodule

bind phy_reg_seq phy_reg_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .busy       (busy),
  .ctrlWord   (ctrlWord),
  .statWord   (statWord),
  .rdData     (rdData),
  .done       (done),
  .timeoutErr (timeoutErr)
);

// File: tb/test_phy_reg_seq.sv
`timescale 1ns/1ps
module test_phy_reg_seq;

  localparam int GAP   = 2;
  localparam int POLLS = 10;
  localparam int LAST_OK_DELAY = (POLLS - 1) * (GAP + 1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic        busy;
  logic [19:0] ctrlWord;
  logic [16:0] statWord;
  logic [15:0] rdData;
  logic        done;
  logic        timeoutErr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // responder controls
  int ackDly    = 1;
  int stuckMode = 0;   // 0 normal, 1 ack never rises, 2 ack never falls

  always #10 clk = ~clk;

  phy_reg_seq #(.POLL_GAP(GAP), .MAX_POLLS(POLLS)) i_phy_reg_seq (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .busy       (busy),
    .ctrlWord   (ctrlWord),
    .statWord   (statWord),
    .rdData     (rdData),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

  // ---------------- simple PHY responder ----------------
  logic        ackQ;
  logic [15:0] latA;
  logic [15:0] latD;
  logic [15:0] phyMem [16];
  int          cnt;
  int          rises;
  logic [15:0] seqLog;
  logic        wantRaw;
  logic        wantEff;

  assign wantRaw = (ctrlWord[19:16] != 4'h0);
  assign wantEff = (stuckMode == 1) ? 1'b0 : (stuckMode == 2) ? (ackQ | wantRaw) : wantRaw;
  assign statWord = {ackQ, (ackQ && ctrlWord[19]) ? phyMem[latA[3:0]] : 16'hDEAD};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ   <= 1'b0;
      cnt    <= 0;
      rises  <= 0;
      seqLog <= '0;
      latA   <= '0;
      latD   <= '0;
      for (int i = 0; i < 16; i++) phyMem[i] <= 16'(16'h1357 * (i + 1));
    end else if (wantEff != ackQ) begin
      if (cnt >= ackDly - 1) begin
        ackQ <= wantEff;
        cnt  <= 0;
        if (wantEff) begin
          rises  <= rises + 1;
          seqLog <= {seqLog[11:0], ctrlWord[19:16]};
          if (ctrlWord[16]) latA <= ctrlWord[15:0];
          if (ctrlWord[17]) latD <= ctrlWord[15:0];
          if (ctrlWord[18]) phyMem[latA[3:0]] <= latD;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      cnt <= 0;
    end
  end

  // ---------------- bench state ----------------
  logic [15:0] expMem [16];
  logic [15:0] lastRd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one operation, issued in the current (negedge) cycle
  task automatic doOp(input bit wr, input logic [15:0] a, input logic [15:0] d,
                      input bit expErr, input int expRise, input int expCyc,
                      input bit noise);
    int n;
    int r0;
    bit got;
    logic [19:0] prevCtrl;
    r0 = rises;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0; reqAddr = 16'h0; reqData = 16'h0;
    chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
    n = 0; got = 0; prevCtrl = ctrlWord;
    while (!got && n < 600) begin
      if (noise && (n % 7 == 3)) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0005; reqData = 16'hBEEF;
      end
      @(posedge clk); n++; @(negedge clk);
      reqValid = 1'b0;
      if (done) got = 1; else prevCtrl = ctrlWord;
    end
    chk(got, "R10", "done seen", got, 1);
    if (got) begin
      chk(timeoutErr == expErr, expErr ? "R9" : "R10", "timeoutErr", timeoutErr, expErr);
      chk(ctrlWord == 20'h0 && prevCtrl == 20'h0, "R9", "zero word before/at done",
          {12'h0, prevCtrl[19:0] != 0, 3'h0, ctrlWord[19:16] != 0}, 0);
      if (!wr) begin
        if (expErr) chk(rdData == lastRd, "R9", "rdData held on timeout", rdData, lastRd);
        else begin
          chk(rdData == expMem[a[3:0]], "R5", "read data", rdData, expMem[a[3:0]]);
          lastRd = expMem[a[3:0]];
        end
      end
      if (expRise >= 0) chk(rises - r0 == expRise, "R7", "ack rise count", rises - r0, expRise);
      if (!expErr) begin
        if (wr) chk(seqLog[11:0] == 12'h124, "R7", "write strobe order", seqLog[11:0], 12'h124);
        else    chk(seqLog[7:0] == 8'h18, "R7", "read strobe order", seqLog[7:0], 8'h18);
        if (wr) expMem[a[3:0]] = d;
      end
      if (expCyc >= 0) chk(n == expCyc, expErr ? "R9" : "R8", "cycles to done", n, expCyc);
    end
  endtask

  task automatic settle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) expMem[i] = 16'(16'h1357 * (i + 1));
    settle(3);
    // R1 reset state
    chk(ctrlWord == 20'h0 && busy == 1'b0 && done == 1'b0 && timeoutErr == 1'b0 && rdData == 16'h0,
        "R1", "reset outputs", {ctrlWord[19:16], busy, done, timeoutErr, rdData}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(ctrlWord == 20'h0 && busy == 1'b0 && done == 1'b0 && rdData == 16'h0,
        "R1", "outputs after reset", {ctrlWord[19:16], busy, done, rdData}, 0);

    // R8 exact timing of a read with one-cycle responder
    ackDly = 1;
    doOp(1'b0, 16'h0003, 16'h0, 1'b0, 2, 17, 1'b0);

    // R4 R5 R6 R8 sweep of responder latency up to the last accepted sample
    begin
      int dl[9] = '{1, 2, 3, 5, 8, 13, 20, 26, LAST_OK_DELAY};
      foreach (dl[k]) begin
        logic [15:0] a;
        logic [15:0] d;
        ackDly = dl[k];
        a = 16'((k * 5 + 2) % 16) | 16'hA0F0;
        d = 16'(16'h3C5A ^ (k * 16'h0911) ^ dl[k]);
        doOp(1'b1, a, d, 1'b0, 3, -1, 1'b0);
        doOp(1'b0, a, 16'h0, 1'b0, 2, -1, 1'b0);
        doOp(1'b0, 16'((k + 9) % 16), 16'h0, 1'b0, 2, -1, 1'b0);
      end
    end

    // R9 acknowledge one cycle too late: read aborted on the first wait
    ackDly = LAST_OK_DELAY + 1;
    doOp(1'b0, 16'h0004, 16'h0, 1'b1, -1, 3 + (POLLS - 1) * (GAP + 1), 1'b0);
    settle(2 * LAST_OK_DELAY + 10);

    // R9 acknowledge never rises: write aborted, PHY untouched
    ackDly = 1; stuckMode = 1;
    doOp(1'b1, 16'h0006, 16'h7777, 1'b1, 0, 3 + (POLLS - 1) * (GAP + 1), 1'b0);
    stuckMode = 0;
    settle(4);
    doOp(1'b0, 16'h0006, 16'h0, 1'b0, 2, -1, 1'b0);

    // R9 acknowledge never falls: read aborted during address release
    stuckMode = 2;
    doOp(1'b0, 16'h0007, 16'h0, 1'b1, 1, 2 + (GAP + 1) + 1 + (POLLS - 1) * (GAP + 1) + 1, 1'b0);
    stuckMode = 0;
    settle(6);

    // R11 requests during busy are ignored
    ackDly = 2;
    doOp(1'b1, 16'h0009, 16'h1F2E, 1'b0, 3, -1, 1'b1);
    settle(6);
    chk(done == 1'b0 && busy == 1'b0, "R11", "no extra op after noise", {done, busy}, 0);
    doOp(1'b0, 16'h0005, 16'h0, 1'b0, 2, -1, 1'b0);
    doOp(1'b0, 16'h0009, 16'h0, 1'b0, 2, -1, 1'b0);

    // R3 full-width data patterns through write and read back
    ackDly = 1;
    doOp(1'b1, 16'h000C, 16'hFFFF, 1'b0, 3, -1, 1'b0);
    doOp(1'b0, 16'h000C, 16'h0, 1'b0, 2, -1, 1'b0);
    doOp(1'b1, 16'h000C, 16'h0000, 1'b0, 3, -1, 1'b0);
    doOp(1'b0, 16'h000C, 16'h0, 1'b0, 2, -1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // watchdog
  always @(posedge clk) cyc <= cyc + 1;
  initial begin
    wait (cyc >= 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule